// File: doc/BRIEF.md
# Processor Execution-State and Trap Controller

This block holds the two bits of processor execution state: control or normal, and zero base or non-zero base. It decides how each fault and event reported by the processor is handled. Faults are sampled on the instruction-complete strobe. Depending on the base mode, a fault either records a cause and forces the interrupt branch, or stops the processor clock and latches the stop. Asynchronous events, the real-time clock and I/O completion, record a cause and set a pending-interrupt flag. That flag turns into a branch request only at an instruction boundary taken in normal state.

The microcode sequencer sees a branch request, saves the return point and answers with an acknowledge. The acknowledge moves the block to control state, zero base. Cause bits gather in a descriptor register until software clears them. Software loads the execution state directly.

Top module: `trapStateCtl`

## Requirements
- R1: After reset the block is in control state with zero base. The pending flag, the branch request, the descriptor strobe, all cause bits and the clock-stop flag are 0, and privOk is 1.
- R2: privOk is 1 exactly when the state is zero base. A cycle with stateLoad high and no branch acknowledge loads control mode from loadControl and zero base from loadZeroBase, visible the cycle after.
- R3: In non-zero base, on instrDone, each of these sets its cause bit: parity (bit 0), address (bit 1), time limit (bit 2), unassigned opcode (bit 3), absent option (bit 4), invalid halt (bit 5), bad communicate address (bit 6) and privileged attempt (bit 7). The cycle after, descStore pulses and branchReq rises in either control or normal state, with the pending flag left unchanged.
- R4: In zero base, on instrDone, a parity, address, time-limit, opcode, option or halt fault sets clkHalted and records no cause. clkHalted stays set until restart is pulsed.
- R5: In zero base a privileged attempt or a bad communicate address has no effect. In non-zero base an invalid I/O operation has no effect. Faults without instrDone have no effect.
- R6: In zero base, an invalid I/O operation on instrDone sets cause bit 8 and the pending flag, unless a clock-stop fault is reported on the same boundary.
- R7: rtcTick sets cause bit 9 and ioComplete sets cause bit 10 on any cycle, without instrDone. Each also sets the pending flag and pulses descStore.
- R8: In control state, a set pending flag does not raise branchReq at an instruction boundary.
- R9: In normal state, branchReq rises on the first instrDone boundary at which the pending flag is set or is being set, and not before.
- R10: A branchAck while branchReq is high clears branchReq and the pending flag and enters control state, zero base. The cause bits are kept.
- R11: descClear empties the cause register and the pending flag. A cause arriving in the same cycle survives.
- R12: branchReq holds until acknowledged. While branchReq or clkHalted is set, instrDone and the faults that come with it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrDone | input | 1 | Instruction-complete strobe that qualifies the faults |
| faultParity | input | 1 | Memory parity error |
| faultAddr | input | 1 | Memory address error |
| faultTime | input | 1 | Instruction time limit exceeded |
| badOpcode | input | 1 | Unassigned operation code |
| absentOption | input | 1 | Operation needs an option that is not fitted |
| badHalt | input | 1 | Invalid halt |
| badCommAddr | input | 1 | Invalid communicate address |
| privAttempt | input | 1 | Privileged instruction attempted |
| badIoOp | input | 1 | Invalid I/O operation |
| rtcTick | input | 1 | Real-time clock event |
| ioComplete | input | 1 | I/O result descriptor stored |
| branchAck | input | 1 | Sequencer has taken the branch |
| descClear | input | 1 | Clear cause bits and pending flag |
| restart | input | 1 | Operator restart after clock stop |
| stateLoad | input | 1 | Load execution state |
| loadControl | input | 1 | Control-mode value to load |
| loadZeroBase | input | 1 | Zero-base value to load |
| intFlag | output | 1 | Pending-interrupt flag |
| branchReq | output | 1 | Interrupt branch request |
| descStore | output | 1 | Descriptor store strobe |
| descCause | output | 11 | Accumulated cause bits |
| privOk | output | 1 | Privileged instructions allowed |
| clkHalted | output | 1 | Processor clock stopped |
| inControl | output | 1 | Control state |
| inZeroBase | output | 1 | Zero base |

## Verification
A wrong base bit swaps trapping and clock stop. That shows one cycle after the faulting boundary, as branchReq high where clkHalted was expected, or the reverse. A wrong control bit shows as a deferred branch that fires too early or never fires, seen at the next instrDone. Cause-register faults show in descCause the cycle after the event. A lost or stuck pending flag shows when the state is loaded to normal and a boundary follows.

// File: rtl/trapPkg.sv
package trapPkg;
  localparam int CAUSE_W  = 11;
  localparam int C_PARITY = 0;
  localparam int HALT_TOP = 5;   // bits 0..5 stop the clock in zero base
  localparam int TRAP_TOP = 7;   // bits 0..7 trap in non-zero base
  localparam int C_BADIO  = 8;
  localparam int C_RTC    = 9;
  localparam int C_IODONE = 10;

  typedef struct packed {
    logic [CAUSE_W-1:0] causeSet;
    logic               setInt;
    logic               branchSet;
    logic               haltSet;
  } trapCmdT;
endpackage

// File: rtl/trapControl.sv
module trapControl
  import trapPkg::*;
(
  input  logic               instrDone,
  input  logic [CAUSE_W-1:0] evIn,
  input  logic               inControl,
  input  logic               inZeroBase,
  input  logic               intFlag,
  input  logic               branchReq,
  input  logic               clkHalted,
  output trapCmdT            cmd
);
  logic                boundary;
  logic                haltHit;
  logic                ioHit;
  logic [TRAP_TOP:0]   nzHits;

  always_comb begin
    boundary = instrDone && !clkHalted && !branchReq;
    haltHit  = boundary && inZeroBase && (|evIn[HALT_TOP:C_PARITY]);
    nzHits   = (boundary && !inZeroBase) ? evIn[TRAP_TOP:C_PARITY] : '0;
    ioHit    = boundary && inZeroBase && !haltHit && evIn[C_BADIO];

    cmd = '0;
    cmd.causeSet[TRAP_TOP:C_PARITY] = nzHits;
    cmd.causeSet[C_BADIO]  = ioHit;
    cmd.causeSet[C_RTC]    = evIn[C_RTC];
    cmd.causeSet[C_IODONE] = evIn[C_IODONE];
    cmd.setInt    = ioHit || evIn[C_RTC] || evIn[C_IODONE];
    cmd.haltSet   = haltHit;
    cmd.branchSet = (|nzHits) ||
                    (boundary && !inControl && !haltHit && (intFlag || cmd.setInt));
  end
endmodule

// File: rtl/trapDatapath.sv
module trapDatapath
  import trapPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  trapCmdT            cmd,
  input  logic               branchAck,
  input  logic               descClear,
  input  logic               restart,
  input  logic               stateLoad,
  input  logic               loadControl,
  input  logic               loadZeroBase,
  output logic               intFlag,
  output logic               branchReq,
  output logic               descStore,
  output logic [CAUSE_W-1:0] descCause,
  output logic               privOk,
  output logic               clkHalted,
  output logic               inControl,
  output logic               inZeroBase
);
  logic takeBranch;
  assign takeBranch = branchReq && branchAck;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intFlag    <= 1'b0;
      branchReq  <= 1'b0;
      descStore  <= 1'b0;
      descCause  <= '0;
      clkHalted  <= 1'b0;
      inControl  <= 1'b1;
      inZeroBase <= 1'b1;
    end else begin
      descCause <= (descClear ? '0 : descCause) | cmd.causeSet;
      intFlag   <= (intFlag && !descClear && !takeBranch) || cmd.setInt;
      descStore <= |cmd.causeSet;
      branchReq <= cmd.branchSet || (branchReq && !branchAck);
      clkHalted <= cmd.haltSet || (clkHalted && !restart);
      if (takeBranch) begin
        inControl  <= 1'b1;
        inZeroBase <= 1'b1;
      end else if (stateLoad) begin
        inControl  <= loadControl;
        inZeroBase <= loadZeroBase;
      end
    end
  end

  assign privOk = inZeroBase;

  assert_hold_branch_R12: assert property (@(posedge clk) disable iff (!rstN)
    branchReq && !branchAck |=> branchReq);
  assert_ack_mode_R10: assert property (@(posedge clk) disable iff (!rstN)
    branchReq && branchAck |=> inControl && inZeroBase && !branchReq);
  assert_halt_latch_R4: assert property (@(posedge clk) disable iff (!rstN)
    clkHalted && !restart |=> clkHalted);
  assert_int_has_desc_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intFlag) |-> descStore);
  assert_desc_nonzero_R3: assert property (@(posedge clk) disable iff (!rstN)
    descStore |-> descCause != '0);
endmodule

// File: rtl/trapStateCtl.sv
module trapStateCtl
  import trapPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrDone,
  input  logic               faultParity,
  input  logic               faultAddr,
  input  logic               faultTime,
  input  logic               badOpcode,
  input  logic               absentOption,
  input  logic               badHalt,
  input  logic               badCommAddr,
  input  logic               privAttempt,
  input  logic               badIoOp,
  input  logic               rtcTick,
  input  logic               ioComplete,
  input  logic               branchAck,
  input  logic               descClear,
  input  logic               restart,
  input  logic               stateLoad,
  input  logic               loadControl,
  input  logic               loadZeroBase,
  output logic               intFlag,
  output logic               branchReq,
  output logic               descStore,
  output logic [CAUSE_W-1:0] descCause,
  output logic               privOk,
  output logic               clkHalted,
  output logic               inControl,
  output logic               inZeroBase
);
  logic [CAUSE_W-1:0] evIn;
  trapCmdT            cmd;

  assign evIn = {ioComplete, rtcTick, badIoOp, privAttempt, badCommAddr,
                 badHalt, absentOption, badOpcode, faultTime, faultAddr, faultParity};

  trapControl uCtl (
    .instrDone(instrDone), .evIn(evIn), .inControl(inControl),
    .inZeroBase(inZeroBase), .intFlag(intFlag), .branchReq(branchReq),
    .clkHalted(clkHalted), .cmd(cmd)
  );

  trapDatapath uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .branchAck(branchAck),
    .descClear(descClear), .restart(restart), .stateLoad(stateLoad),
    .loadControl(loadControl), .loadZeroBase(loadZeroBase),
    .intFlag(intFlag), .branchReq(branchReq), .descStore(descStore),
    .descCause(descCause), .privOk(privOk), .clkHalted(clkHalted),
    .inControl(inControl), .inZeroBase(inZeroBase)
  );
endmodule

// File: tb/tb_trapStateCtl.sv
module tb_trapStateCtl;
  localparam int PERIOD = 10;
  localparam int NVEC = 14;
  // {ctl, zero, done, ev[10:0], expCause[10:0], expInt, expBr, expHalt}
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b0,1'b0,1'b1,11'h001,11'h001,1'b0,1'b1,1'b0}, // R3 parity, normal nz
    {1'b1,1'b0,1'b1,11'h080,11'h080,1'b0,1'b1,1'b0}, // R3 privileged, control nz
    {1'b1,1'b1,1'b1,11'h001,11'h000,1'b0,1'b0,1'b1}, // R4 parity zero base
    {1'b0,1'b1,1'b1,11'h020,11'h000,1'b0,1'b0,1'b1}, // R4 invalid halt
    {1'b1,1'b1,1'b1,11'h080,11'h000,1'b0,1'b0,1'b0}, // R5 priv in zero base
    {1'b1,1'b1,1'b1,11'h040,11'h000,1'b0,1'b0,1'b0}, // R5 comm addr zero base
    {1'b0,1'b0,1'b1,11'h100,11'h000,1'b0,1'b0,1'b0}, // R5 bad I/O nz
    {1'b1,1'b1,1'b1,11'h100,11'h100,1'b1,1'b0,1'b0}, // R6 bad I/O control
    {1'b0,1'b1,1'b1,11'h100,11'h100,1'b1,1'b1,1'b0}, // R6 bad I/O normal
    {1'b1,1'b1,1'b0,11'h200,11'h200,1'b1,1'b0,1'b0}, // R7 clock tick
    {1'b0,1'b0,1'b0,11'h400,11'h400,1'b1,1'b0,1'b0}, // R7 I/O complete
    {1'b0,1'b0,1'b0,11'h001,11'h000,1'b0,1'b0,1'b0}, // R5 fault without done
    {1'b0,1'b0,1'b1,11'h00C,11'h00C,1'b0,1'b1,1'b0}, // R3 time+opcode
    {1'b0,1'b1,1'b1,11'h102,11'h000,1'b0,1'b0,1'b1}  // R4 halt beats I/O
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic instrDone = 0, branchAck = 0, descClear = 0, restart = 0;
  logic stateLoad = 0, loadControl = 0, loadZeroBase = 0;
  logic [10:0] ev = '0;
  logic intFlag, branchReq, descStore, privOk, clkHalted, inControl, inZeroBase;
  logic [10:0] descCause;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  trapStateCtl dut (
    .clk(clk), .rstN(rstN), .instrDone(instrDone),
    .faultParity(ev[0]), .faultAddr(ev[1]), .faultTime(ev[2]),
    .badOpcode(ev[3]), .absentOption(ev[4]), .badHalt(ev[5]),
    .badCommAddr(ev[6]), .privAttempt(ev[7]), .badIoOp(ev[8]),
    .rtcTick(ev[9]), .ioComplete(ev[10]), .branchAck(branchAck),
    .descClear(descClear), .restart(restart), .stateLoad(stateLoad),
    .loadControl(loadControl), .loadZeroBase(loadZeroBase),
    .intFlag(intFlag), .branchReq(branchReq), .descStore(descStore),
    .descCause(descCause), .privOk(privOk), .clkHalted(clkHalted),
    .inControl(inControl), .inZeroBase(inZeroBase)
  );

  function automatic string vecTag(int i);
    case (i)
      0, 1, 12:    return "R3";
      2, 3, 13:    return "R4";
      4, 5, 6, 11: return "R5";
      7, 8:        return "R6";
      default:     return "R7";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: inputs already set after a negedge; clear pulses at next negedge
  task automatic cyc();
    @(negedge clk);
    instrDone = 0; branchAck = 0; descClear = 0; restart = 0;
    stateLoad = 0; ev = '0;
  endtask

  task automatic doReset();
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  task automatic loadState(logic c, logic z);
    stateLoad = 1; loadControl = c; loadZeroBase = z;
    cyc();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    doReset();
    // R1 reset state
    check("R1", {25'd0, inControl, inZeroBase, intFlag, branchReq, clkHalted, privOk, descStore},
          {25'd0, 7'b1100010});
    check("R1 cause", 32'(descCause), 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      logic [27:0] v;
      v = VEC[i];
      doReset();
      loadState(v[27], v[26]);
      instrDone = v[25]; ev = v[24:14];
      cyc();
      check(vecTag(i), {7'd0, descCause, 10'd0, descStore, intFlag, branchReq, clkHalted},
            {7'd0, v[13:3], 10'd0, (v[13:3] != 0), v[2], v[1], v[0]});
    end

    // Directed sequence
    doReset();
    loadState(1'b0, 1'b0);
    check("R2 load normal nz", {30'd0, privOk, inControl}, 32'h0);
    ev[9] = 1; cyc();
    check("R9 no branch before boundary", {30'd0, intFlag, branchReq}, 32'h2);
    instrDone = 1; cyc();
    check("R9 branch at boundary", 32'(branchReq), 32'h1);
    instrDone = 1; ev[0] = 1; cyc();
    check("R12 held, done ignored", {20'd0, branchReq, descCause}, {20'd0, 1'b1, 11'h200});
    branchAck = 1; cyc();
    check("R10 ack", {17'd0, branchReq, inControl, inZeroBase, intFlag, descCause},
          {17'd0, 4'b0110, 11'h200});
    descClear = 1; ev[10] = 1; cyc();
    check("R11 clear with new cause", {20'd0, intFlag, descCause}, {20'd0, 1'b1, 11'h400});
    descClear = 1; cyc();
    check("R11 clear", {20'd0, intFlag, descCause}, 32'h0);
    ev[9] = 1; cyc();
    instrDone = 1; cyc();
    check("R8 deferred in control", {30'd0, intFlag, branchReq}, 32'h2);
    loadState(1'b0, 1'b1);
    check("R8 no branch on load", 32'(branchReq), 32'h0);
    instrDone = 1; cyc();
    check("R9 branch after normal", 32'(branchReq), 32'h1);
    branchAck = 1; cyc();
    instrDone = 1; ev[1] = 1; cyc();
    repeat (3) cyc();
    check("R4 halt latched", {31'd0, clkHalted}, 32'h1);
    instrDone = 1; ev[8] = 1; cyc();
    check("R12 done ignored halted", {20'd0, intFlag, descCause}, {20'd0, 1'b0, 11'h200});
    restart = 1; cyc();
    check("R4 restart", 32'(clkHalted), 32'h0);
    summary();
  end
endmodule